// File: doc/BRIEF.md
# Interrupt Controller Register Port

This block is the byte-wide programming port of a single interrupt controller. A one-bit address selects either the command port (address 0) or the data port (address 1). Writes to the command port either begin the initialization sequence or carry one of two operational command formats. Writes to the data port either step the initialization sequence or load the mask register. The block keeps the vector base, the operating mode bits, the mask, the read-select flag and the poll flag.

The priority resolver sits beside this port. It owns the request and in-service registers and the rotation base. It feeds its request and in-service contents back to this block, together with its best pending line. In return it receives one-cycle command strobes with a line-number field. Reads return the request, in-service or mask register, or a poll response when poll has been armed. A read and a write in the same cycle are treated as a write for poll purposes: such a read still returns data but does not disarm poll.

Top module: `picRegPort`

## Requirements
- R1: After reset the mask, vector base, mode flags (auto-EOI, nested, rotate-on-auto-EOI, special mask) and read-select are all zero, poll is disarmed, `initBusy` is low and no strobe is asserted.
- R2: An address-0 write with bit 4 = 1 pulses `rsInit`. It clears the mask, special mask and read-select. If bit 0 of that word is 0, it also clears `autoEoi` and `nestedMode`.
- R3: After that word, `initBusy` stays high while data-port writes are consumed as follows:
  - the first data-port write loads `vecBase` with data bits 7..3, and bits 2..0 read as zero;
  - the second data-port write is taken without effect;
  - the sequence then ends, unless bit 0 of the starting word was 1, in which case one further word is taken.
- R4: The fourth word sets `nestedMode` from bit 4 and `autoEoi` from bit 1, then ends the sequence.
- R5: A data-port write outside initialization loads the mask. Data-port writes during initialization leave the mask unchanged.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 is a status command:
  - bit 2 = 1 arms poll;
  - bit 1 = 1 loads read-select from bit 0, and bit 1 = 0 leaves read-select as it was;
  - bit 6 = 1 loads the special mask from bit 5.
- R7: An address-0 write with bits 4 and 3 both 0 is a priority command, with its code in bits 7..5. Code 0 clears `rotateOnAeoi` and code 4 sets it.
- R8: Priority codes drive the strobes as follows (bits 2..0 give the line where one is used):
  - codes 1 and 5 pulse `rsEoi` with `rsSpecific` = 0;
  - codes 3 and 7 pulse `rsEoi` with `rsSpecific` = 1 and `rsLine` = bits 2..0;
  - `rsRotate` is 1 for codes 5 and 7;
  - code 6 pulses `rsSetPrio` with `rsLine` = bits 2..0;
  - code 2 pulses nothing.
- R9: With poll disarmed, an address-0 read returns `isrIn` when read-select is 1 and `irqIn` when it is 0. An address-1 read returns the mask.
- R10: A read while poll is armed returns 0x80 | `pendLine` when `pendValid` is 1, and then pulses `rsPollClr` with `rsLine` = `pendLine`. When `pendValid` is 0 it returns 0x07 and pulses nothing. Either read disarms poll.
- R11: Every strobe is registered. It is high for exactly the one cycle after the clock edge that accepts the write or poll read, and at most one of `rsInit`, `rsEoi`, `rsSetPrio` and `rsPollClr` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte (combinational) |
| irqIn | input | 8 | Request register from the resolver |
| isrIn | input | 8 | In-service register from the resolver |
| pendValid | input | 1 | Resolver has a line to deliver |
| pendLine | input | 3 | That line's number |
| vecBase | output | 8 | Vector base, low three bits zero |
| maskOut | output | 8 | Mask register |
| autoEoi | output | 1 | Automatic end-of-interrupt mode |
| nestedMode | output | 1 | Special fully nested mode |
| rotateOnAeoi | output | 1 | Rotate on automatic EOI |
| specialMask | output | 1 | Special mask mode |
| initBusy | output | 1 | Initialization sequence in progress |
| rsInit | output | 1 | Strobe: clear edge request state and rotation base |
| rsEoi | output | 1 | Strobe: end of interrupt |
| rsSpecific | output | 1 | Qualifies rsEoi: use rsLine |
| rsRotate | output | 1 | Qualifies rsEoi: rotate after clearing |
| rsSetPrio | output | 1 | Strobe: set lowest priority to rsLine |
| rsPollClr | output | 1 | Strobe: clear request and in-service of rsLine |
| rsLine | output | 3 | Line field for strobes |

## Verification
Register state and strobes change at the clock edge that accepts a write, so they are due exactly one cycle after the write is presented. The bench drives each write at a falling edge and checks the effects at the next falling edge, while a strobe is still high. Read data is combinational, so it is sampled a few nanoseconds after `rdEn` is raised, before the accepting edge. Poll disarming and the poll clear strobe are then checked one falling edge later.

// File: rtl/pic_regs_pkg.sv
package pic_regs_pkg;
  localparam int DATA_W  = 8;
  localparam int LINE_W  = 3;
  localparam int LINES   = 1 << LINE_W;
  localparam int CODE_W  = 3;
  localparam int BASE_W  = DATA_W - LINE_W;

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_W3, ST_W4} initStep_e;

  typedef struct packed {
    logic initWord;
    logic baseWord;
    logic thirdWord;
    logic modeWord;
    logic maskWord;
    logic statusWord;
    logic prioWord;
    logic pollRead;
  } ctlStrobe_t;
endpackage

// File: rtl/picRegCtl.sv
module picRegCtl
  import pic_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       addr,
  input  logic       bitInit,
  input  logic       bitStatus,
  input  logic       bitFourth,
  input  logic       pollArmed,
  output ctlStrobe_t strb,
  output logic       initBusy
);
  initStep_e step;
  logic      needFourth;

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (!addr) begin
        if (bitInit)        strb.initWord   = 1'b1;
        else if (bitStatus) strb.statusWord = 1'b1;
        else                strb.prioWord   = 1'b1;
      end else begin
        unique case (step)
          ST_RUN:  strb.maskWord  = 1'b1;
          ST_BASE: strb.baseWord  = 1'b1;
          ST_W3:   strb.thirdWord = 1'b1;
          ST_W4:   strb.modeWord  = 1'b1;
          default: strb.maskWord  = 1'b0;
        endcase
      end
    end
    strb.pollRead = rdEn && pollArmed && !wrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step       <= ST_RUN;
      needFourth <= 1'b0;
    end else if (strb.initWord) begin
      step       <= ST_BASE;
      needFourth <= bitFourth;
    end else if (strb.baseWord) begin
      step <= ST_W3;
    end else if (strb.thirdWord) begin
      step <= needFourth ? ST_W4 : ST_RUN;
    end else if (strb.modeWord) begin
      step <= ST_RUN;
    end
  end

  assign initBusy = (step != ST_RUN);

  assert_init_enters_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.initWord) |-> step == ST_BASE);
  assert_w4_after_w3_R3: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_W4) |-> ($past(step) == ST_W3 || $past(step) == ST_W4));
  assert_w4_only_when_asked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_W4) |-> needFourth);
endmodule

// File: rtl/picRegData.sv
module picRegData
  import pic_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] irqIn,
  input  logic [DATA_W-1:0] isrIn,
  input  logic              pendValid,
  input  logic [LINE_W-1:0] pendLine,
  output logic [DATA_W-1:0] rdData,
  output logic              pollArmed,
  output logic [DATA_W-1:0] vecBase,
  output logic [DATA_W-1:0] maskOut,
  output logic              autoEoi,
  output logic              nestedMode,
  output logic              rotateOnAeoi,
  output logic              specialMask,
  output logic              rsInit,
  output logic              rsEoi,
  output logic              rsSpecific,
  output logic              rsRotate,
  output logic              rsSetPrio,
  output logic              rsPollClr,
  output logic [LINE_W-1:0] rsLine
);
  localparam int CODES = 1 << CODE_W;
  localparam logic [DATA_W-1:0] POLL_EMPTY = DATA_W'(LINES - 1);

  logic [BASE_W-1:0] baseReg;
  logic              readSel;
  logic [CODES-1:0]  codeHit;
  logic [CODE_W-1:0] prioCode;

  assign prioCode = wrData[DATA_W-1 -: CODE_W];

  for (genvar c = 0; c < CODES; c++) begin : g_code
    assign codeHit[c] = strb.prioWord && (prioCode == CODE_W'(c));
  end

  always_comb begin
    if (pollArmed)
      rdData = pendValid ? {1'b1, {(DATA_W-1-LINE_W){1'b0}}, pendLine} : POLL_EMPTY;
    else if (addr)
      rdData = maskOut;
    else
      rdData = readSel ? isrIn : irqIn;
  end

  assign vecBase = {baseReg, {LINE_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg      <= '0;
      maskOut      <= '0;
      readSel      <= 1'b0;
      pollArmed    <= 1'b0;
      autoEoi      <= 1'b0;
      nestedMode   <= 1'b0;
      rotateOnAeoi <= 1'b0;
      specialMask  <= 1'b0;
    end else begin
      if (strb.pollRead) pollArmed <= 1'b0;
      if (strb.initWord) begin
        maskOut     <= '0;
        specialMask <= 1'b0;
        readSel     <= 1'b0;
        if (!wrData[0]) begin
          autoEoi    <= 1'b0;
          nestedMode <= 1'b0;
        end
      end
      if (strb.baseWord) baseReg <= wrData[DATA_W-1:LINE_W];
      if (strb.modeWord) begin
        nestedMode <= wrData[4];
        autoEoi    <= wrData[1];
      end
      if (strb.maskWord) maskOut <= wrData;
      if (strb.statusWord) begin
        if (wrData[2]) pollArmed   <= 1'b1;
        if (wrData[1]) readSel     <= wrData[0];
        if (wrData[6]) specialMask <= wrData[5];
      end
      if (codeHit[0]) rotateOnAeoi <= 1'b0;
      if (codeHit[4]) rotateOnAeoi <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsInit     <= 1'b0;
      rsEoi      <= 1'b0;
      rsSpecific <= 1'b0;
      rsRotate   <= 1'b0;
      rsSetPrio  <= 1'b0;
      rsPollClr  <= 1'b0;
      rsLine     <= '0;
    end else begin
      rsInit     <= strb.initWord;
      rsEoi      <= codeHit[1] | codeHit[3] | codeHit[5] | codeHit[7];
      rsSpecific <= codeHit[3] | codeHit[7];
      rsRotate   <= codeHit[5] | codeHit[7];
      rsSetPrio  <= codeHit[6];
      rsPollClr  <= strb.pollRead && pendValid;
      if (strb.pollRead && pendValid)
        rsLine <= pendLine;
      else if (strb.prioWord)
        rsLine <= wrData[LINE_W-1:0];
      else
        rsLine <= '0;
    end
  end

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rsInit, rsEoi, rsSetPrio, rsPollClr}));
  assert_eoi_from_prio_R8: assert property (@(posedge clk) disable iff (!rstN)
    rsEoi |-> $past(strb.prioWord));
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(maskOut) |-> $past(strb.maskWord || strb.initWord));
  assert_poll_disarm_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.pollRead) |-> !pollArmed);
  assert_pollclr_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    rsPollClr |-> $past(strb.pollRead && pendValid));
endmodule

// File: rtl/picRegPort.sv
module picRegPort
  import pic_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] irqIn,
  input  logic [DATA_W-1:0] isrIn,
  input  logic              pendValid,
  input  logic [LINE_W-1:0] pendLine,
  output logic [DATA_W-1:0] vecBase,
  output logic [DATA_W-1:0] maskOut,
  output logic              autoEoi,
  output logic              nestedMode,
  output logic              rotateOnAeoi,
  output logic              specialMask,
  output logic              initBusy,
  output logic              rsInit,
  output logic              rsEoi,
  output logic              rsSpecific,
  output logic              rsRotate,
  output logic              rsSetPrio,
  output logic              rsPollClr,
  output logic [LINE_W-1:0] rsLine
);
  ctlStrobe_t strb;
  logic       pollArmed;

  picRegCtl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .bitInit(wrData[4]), .bitStatus(wrData[3]), .bitFourth(wrData[0]),
    .pollArmed(pollArmed), .strb(strb), .initBusy(initBusy)
  );

  picRegData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .irqIn(irqIn), .isrIn(isrIn), .pendValid(pendValid), .pendLine(pendLine),
    .rdData(rdData), .pollArmed(pollArmed), .vecBase(vecBase), .maskOut(maskOut),
    .autoEoi(autoEoi), .nestedMode(nestedMode), .rotateOnAeoi(rotateOnAeoi),
    .specialMask(specialMask), .rsInit(rsInit), .rsEoi(rsEoi),
    .rsSpecific(rsSpecific), .rsRotate(rsRotate), .rsSetPrio(rsSetPrio),
    .rsPollClr(rsPollClr), .rsLine(rsLine)
  );

  assert_init_strobe_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    rsInit |-> $past(wrEn && !addr && wrData[4]));
endmodule

// File: tb/picRegPort_bench.sv
module picRegPort_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0, rdData, irqIn = 8'h5A, isrIn = 8'hC3;
  logic pendValid = 1'b0;
  logic [2:0] pendLine = '0;
  logic [7:0] vecBase, maskOut;
  logic autoEoi, nestedMode, rotateOnAeoi, specialMask, initBusy;
  logic rsInit, rsEoi, rsSpecific, rsRotate, rsSetPrio, rsPollClr;
  logic [2:0] rsLine;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  picRegPort u_picRegPort (.*);

  // {cmd[7:0], eoi, specific, rotate, setPrio, line[2:0], rotAeoiAfter}
  localparam logic [15:0] PRIO_VEC [8] = '{
    {8'h80, 4'b0000, 3'd0, 1'b1},  // code 4 sets rotate-on-auto-EOI
    {8'h20, 4'b1000, 3'd0, 1'b1},  // code 1
    {8'hA0, 4'b1010, 3'd0, 1'b1},  // code 5
    {8'h63, 4'b1100, 3'd3, 1'b1},  // code 3 line 3
    {8'hE5, 4'b1110, 3'd5, 1'b1},  // code 7 line 5
    {8'hC6, 4'b0001, 3'd6, 1'b1},  // code 6 line 6
    {8'h42, 4'b0000, 3'd0, 1'b1},  // code 2 nothing
    {8'h00, 4'b0000, 3'd0, 1'b0}   // code 0 clears
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    #2 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", maskOut, 8'h00);
    chk("R1 base", vecBase, 8'h00);
    chk("R1 flags", {autoEoi, nestedMode, rotateOnAeoi, specialMask, initBusy}, 8'h00);
    chk("R1 strobes", {rsInit, rsEoi, rsSetPrio, rsPollClr}, 8'h00);
    rd(1'b0, d); chk("R1 read irr", d, 8'h5A);

    // R5 mask load, R6/R9 status and read select
    wr(1'b1, 8'hF0); chk("R5 mask load", maskOut, 8'hF0);
    rd(1'b1, d); chk("R9 read mask", d, 8'hF0);
    wr(1'b0, 8'h6B); chk("R6 special mask set", {7'd0, specialMask}, 8'h01);
    rd(1'b0, d); chk("R9 read isr", d, 8'hC3);
    wr(1'b0, 8'h08); rd(1'b0, d); chk("R6 select unchanged", d, 8'hC3);

    // R2 init with fourth word
    wr(1'b0, 8'h11);
    chk("R2 init strobe", {7'd0, rsInit}, 8'h01);
    chk("R2 mask cleared", maskOut, 8'h00);
    chk("R2 smm cleared", {7'd0, specialMask}, 8'h00);
    chk("R3 busy", {7'd0, initBusy}, 8'h01);
    rd(1'b0, d); chk("R2 select cleared", d, 8'h5A);
    chk("R11 init strobe one cycle", {7'd0, rsInit}, 8'h00);
    wr(1'b1, 8'h45); chk("R3 base", vecBase, 8'h40);
    chk("R5 mask untouched in init", maskOut, 8'h00);
    wr(1'b1, 8'h00); chk("R3 waits fourth", {7'd0, initBusy}, 8'h01);
    wr(1'b1, 8'h12);
    chk("R4 mode bits", {6'd0, nestedMode, autoEoi}, 8'h03);
    chk("R4 done", {7'd0, initBusy}, 8'h00);

    // R2/R3 init without fourth word
    wr(1'b0, 8'h10); chk("R2 modes cleared", {6'd0, nestedMode, autoEoi}, 8'h00);
    wr(1'b1, 8'h8F); chk("R3 base2", vecBase, 8'h88);
    wr(1'b1, 8'h00); chk("R3 skip fourth", {7'd0, initBusy}, 8'h00);
    wr(1'b1, 8'h3C); chk("R5 mask after init", maskOut, 8'h3C);

    // R7/R8/R11 priority command table
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, PRIO_VEC[i][15:8]);
      chk("R8 strobes", {4'd0, rsEoi, rsSpecific, rsRotate, rsSetPrio}, {4'd0, PRIO_VEC[i][7:4]});
      if (PRIO_VEC[i][6] || PRIO_VEC[i][4])
        chk("R8 line", {5'd0, rsLine}, {5'd0, PRIO_VEC[i][3:1]});
      chk("R7 rotate flag", {7'd0, rotateOnAeoi}, {7'd0, PRIO_VEC[i][0]});
      @(negedge clk);
      chk("R11 one cycle", {rsEoi, rsSetPrio, 6'd0}, 8'h00);
    end

    // R10 poll with a pending line
    pendValid = 1'b1; pendLine = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b0, d); chk("R10 poll data", d, 8'h85);
    chk("R10 poll clear strobe", {4'd0, rsPollClr, rsLine}, 8'h0D);
    rd(1'b1, d); chk("R10 disarmed", d, 8'h3C);
    chk("R11 pollclr one cycle", {7'd0, rsPollClr}, 8'h00);
    // R10 poll with nothing pending
    pendValid = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b1, d); chk("R10 poll empty", d, 8'h07);
    chk("R10 no strobe", {7'd0, rsPollClr}, 8'h00);
    rd(1'b1, d); chk("R10 disarmed empty", d, 8'h3C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule